// File: doc/BRIEF.md
# Adaptive Interrupt Rate Pacer

The pacer sits between a source of transmit interrupt events and the interrupt line. It measures how many events arrive in a fixed window of ticks and tries to keep the outgoing pulse rate near a programmed target. The window lasts `max(prescale,1) * 250` ticks. At the start of each window the output is held back for a leading stretch of `max(prescale,1) * pace` ticks. Events that arrive in that stretch are collapsed into a single pending flag. The flag is released as one pulse when the stretch ends or when the window closes.

When a window closes, the pacer compares its event count `C` with the target `T` and updates the 8-bit pace value. A rate far above the target saturates the pace. A rate moderately above the target doubles or increments it. A rate below the target decrements or halves it. An idle window clears it. With pacing switched off, the block is a one-cycle pass-through for events and pace stays at zero.

All pins are plain control strobes and levels, sampled on `clk`. There is no back-pressure: an event is never refused. It is either forwarded, merged into the pending flag, or only counted. `tick` is a one-cycle enable that advances the window timer, so a slow time base is formed by pulsing it.

Top module: `intr_pacer`

## Requirements
- R1: After reset `irq_out` is 0, pace is 0 (so nothing is masked), the window index is 0 and there is no pending event.
- R2: While `pace_en` is 0, `irq_out` in cycle n+1 equals `evt` in cycle n. Pace is forced to 0 and the pending flag is cleared.
- R3: The window index advances by one on each cycle with `tick`=1. The window ends on the tick where the index is at or past `max(prescale,1)*250 - 1`; the index then returns to 0. A `prescale` of 0 behaves as 1.
- R4: With `pace_en`=1, while the index is below `max(prescale,1)*pace` and the window is not ending, `irq_out` stays 0 on the next cycle. Events in that time set the pending flag.
- R5: When the output is not masked, or in the window-ending cycle, a pending flag or a current event yields exactly one `irq_out` pulse on the next cycle, and the pending flag clears.
- R6: At a window end with `pace_en`=1, if 2C > 4T the new pace is 255.
- R7: Otherwise, if 2C > 3T the new pace is min(2p+1, 255). Otherwise, if 2C > 2T it is min(p+1, 255).
- R8: Otherwise, if 2C > T the new pace is max(p-1, 0). Otherwise, if C is nonzero it is p/2 (rounded down). If C is 0 it is 0.
- R9: An event in the window-ending cycle counts toward the window that is closing. The count restarts at 0 for the next window. The count saturates at 65535.
- R10: `target` is a 6-bit unsigned value, with meaningful values 2 to 63. The thresholds are exact integer comparisons, so C equal to a threshold falls into the lower band.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base strobe that advances the window index |
| prescale | input | 8 | Window scale; window is max(prescale,1)*250 ticks |
| target | input | 6 | Desired events per window |
| pace_en | input | 1 | 1 enables pacing, 0 gives pass-through |
| evt | input | 1 | Incoming interrupt event strobe |
| irq_out | output | 1 | Paced interrupt pulse |

## Verification
Two functions can land in the same cycle: the window end, and an event arriving while the pending flag is set under a mask. In that cycle the event must count toward the closing window, and the unconditional unmask must release one pulse. Directed windows place a single event on the final tick, or saturate the pace so that the whole window stays masked, and so force this overlap. Every cycle of those windows, and of random ones with sparse ticks and changing targets, is judged against a bench model of the banded pace rule. Exact threshold counts such as C=T, C=1.5T and C=2T are included to pin the band edges.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  localparam int PACE_W = 8;
  localparam int CNT_W  = 16;
  localparam int TGT_W  = 6;
  localparam int CMP_W  = CNT_W + 2;

  typedef logic [PACE_W-1:0] pace_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [TGT_W-1:0]  tgt_t;

  // banded update; 2*C compared with 4T, 3T, 2T and T
  function automatic pace_t next_pace(input cnt_t c, input tgt_t t, input pace_t p);
    logic [CMP_W-1:0] c2, t1, t2, t3, t4;
    logic [PACE_W:0]  dbl;
    pace_t            res;
    c2  = CMP_W'(c) << 1;
    t1  = CMP_W'(t);
    t2  = t1 << 1;
    t3  = t1 + t2;
    t4  = t1 << 2;
    dbl = {p, 1'b1};
    if (c2 > t4)      res = '1;
    else if (c2 > t3) res = dbl[PACE_W] ? '1 : dbl[PACE_W-1:0];
    else if (c2 > t2) res = (p == '1) ? p : p + pace_t'(1);
    else if (c2 > t1) res = (p == '0) ? p : p - pace_t'(1);
    else if (c != '0) res = p >> 1;
    else              res = '0;
    return res;
  endfunction
endpackage

// File: rtl/pace_window_timer.sv
module pace_window_timer
  import pacer_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [PRE_W-1:0] prescale,
  input  pace_t            pace,
  output logic             win_end,
  output logic             in_mask
);
  localparam int IDX_W = PRE_W + 8;
  localparam logic [IDX_W-1:0] STEP = IDX_W'(1);

  logic [IDX_W-1:0] idx, win_len, mask_len;
  logic [PRE_W-1:0] eff_pre;

  assign eff_pre  = (prescale == '0) ? PRE_W'(1) : prescale;
  assign win_len  = IDX_W'(eff_pre) * IDX_W'(250);
  assign mask_len = IDX_W'(eff_pre) * IDX_W'(pace);
  assign win_end  = tick && (idx >= win_len - STEP);
  assign in_mask  = idx < mask_len;

  always_ff @(posedge clk) begin
    if (!rst_n)       idx <= '0;
    else if (win_end) idx <= '0;
    else if (tick)    idx <= idx + STEP;
  end

  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !win_end) |=> (idx == $past(idx) + STEP));
  // R3
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (idx == '0));
endmodule

// File: rtl/pace_adapt.sv
module pace_adapt
  import pacer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  evt,
  input  logic  win_end,
  input  logic  pace_en,
  input  tgt_t  target,
  output pace_t pace
);
  cnt_t cnt, cnt_eff;
  logic [CMP_W-1:0] c2_mon, t4_mon;

  assign cnt_eff = (cnt == '1) ? cnt : cnt + CNT_W'(evt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pace <= '0;
    end else begin
      cnt <= win_end ? '0 : cnt_eff;
      if (!pace_en)     pace <= '0;
      else if (win_end) pace <= next_pace(cnt_eff, target, pace);
    end
  end

  assign c2_mon = CMP_W'(cnt_eff) << 1;
  assign t4_mon = CMP_W'(target) << 2;

  // R6
  sat_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && pace_en && (c2_mon > t4_mon)) |=> (pace == '1));
  // R8
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && pace_en && (cnt_eff == '0)) |=> (pace == '0));
  // R9
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (cnt == '0));
  // R2
  pace_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pace_en |=> (pace == '0));
endmodule

// File: rtl/pace_gate.sv
module pace_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic pace_en,
  input  logic in_mask,
  input  logic win_end,
  output logic irq_out
);
  logic pend, open;

  assign open = !in_mask || win_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_out <= 1'b0;
      pend    <= 1'b0;
    end else if (!pace_en) begin
      irq_out <= evt;
      pend    <= 1'b0;
    end else if (open) begin
      irq_out <= evt || pend;
      pend    <= 1'b0;
    end else begin
      irq_out <= 1'b0;
      pend    <= pend || evt;
    end
  end

  // R2
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pace_en |=> (irq_out == $past(evt)));
  // R4
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pace_en && in_mask && !win_end) |=> !irq_out);
  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pace_en && pend && open) |=> (irq_out && !pend));
endmodule

// File: rtl/intr_pacer.sv
module intr_pacer
  import pacer_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [PRE_W-1:0] prescale,
  input  logic [TGT_W-1:0] target,
  input  logic             pace_en,
  input  logic             evt,
  output logic             irq_out
);
  pace_t pace;
  logic  win_end, in_mask, mask_act;

  assign mask_act = pace_en && in_mask;

  pace_window_timer #(.PRE_W(PRE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .prescale(prescale),
    .pace(pace), .win_end(win_end), .in_mask(in_mask)
  );

  pace_adapt u_adapt (
    .clk(clk), .rst_n(rst_n), .evt(evt), .win_end(win_end),
    .pace_en(pace_en), .target(target), .pace(pace)
  );

  pace_gate u_gate (
    .clk(clk), .rst_n(rst_n), .evt(evt), .pace_en(pace_en),
    .in_mask(mask_act), .win_end(win_end), .irq_out(irq_out)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !irq_out);
endmodule

// File: tb/intr_pacer_test.sv
module intr_pacer_test;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, pace_en = 1'b0, evt = 1'b0;
  logic [7:0] prescale = 8'd1;
  logic [5:0] target = 6'd8;
  logic irq_out;

  int checks = 0, failures = 0, cyc = 0;
  string tag = "R1";
  int m_idx = 0, m_cnt = 0, m_pace = 0;
  bit m_pend = 0, m_irq = 0;

  always #5 clk = ~clk;

  intr_pacer uut (.clk(clk), .rst_n(rst_n), .tick(tick), .prescale(prescale),
    .target(target), .pace_en(pace_en), .evt(evt), .irq_out(irq_out));

  function automatic int band(int c, int t, int p);
    if (2*c > 4*t) return 255;
    if (2*c > 3*t) return (2*p+1 > 255) ? 255 : 2*p+1;
    if (2*c > 2*t) return (p+1 > 255) ? 255 : p+1;
    if (2*c > t)   return (p > 0) ? p-1 : 0;
    if (c != 0)    return p/2;
    return 0;
  endfunction

  task automatic check(bit act, bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s cycle %0d irq_out=%0b expected=%0b", tag, cyc, act, exp);
    end
  endtask

  // model of the posedge just passed, using inputs still on the pins
  task automatic model_step();
    int pre, wlen, ce;
    bit wend, masked, open;
    pre = (prescale == 0) ? 1 : prescale;
    wlen = pre * 250;
    wend = tick && (m_idx >= wlen - 1);
    masked = pace_en && (m_idx < pre * m_pace);
    open = !masked || wend;
    if (!pace_en) begin m_irq = evt; m_pend = 0; end
    else if (open) begin m_irq = evt || m_pend; m_pend = 0; end
    else begin m_irq = 0; m_pend = m_pend || evt; end
    ce = (m_cnt == 65535) ? m_cnt : m_cnt + evt;
    if (!pace_en) m_pace = 0;
    else if (wend) m_pace = band(ce, target, m_pace);
    m_cnt = wend ? 0 : ce;
    if (wend) m_idx = 0; else if (tick) m_idx++;
  endtask

  task automatic step(bit t, bit e);
    @(negedge clk);
    cyc++;
    model_step();
    check(irq_out, m_irq);
    tick = t;
    evt = e;
  endtask

  // one window at prescale 1, tick every cycle; n events at the start
  task automatic run_window(int n, bit last_evt, string nm);
    tag = nm;
    for (int j = 0; j < 250; j++) step(1'b1, (j < n) || (last_evt && j == 249));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    tag = "R1 reset";
    check(irq_out, 1'b0);
    rst_n = 1'b1;
    check(irq_out, 1'b0);

    // pass-through, tick each cycle, random events
    tag = "R2 pacing off";
    for (int j = 0; j < 250; j++) step(1'b1, 1'($urandom_range(0, 1)));

    // enable pacing, target 8 (bands: >16, >12, >8, >4, >0, 0)
    step(1'b1, 1'b0);
    pace_en = 1'b1;
    for (int j = 0; j < 248; j++) step(1'b1, 1'b0);
    tag = "R2 idle";
    step(1'b1, 1'b0);
    run_window(20, 0, "R6 saturate");
    run_window(3, 1, "R4 R5 R9 masked window, last-tick event");
    run_window(6, 0, "R8 decrement");
    run_window(10, 0, "R7 increment");
    run_window(14, 0, "R7 double saturates");
    run_window(10, 0, "R7 increment saturates");
    run_window(6, 0, "R8 decrement from 255");
    run_window(0, 0, "R8 idle clears");
    run_window(6, 0, "R8 decrement floor 0");
    run_window(10, 0, "R7 increment from 0");
    run_window(14, 0, "R7 double");
    run_window(9, 0, "R10 C just above T");
    run_window(8, 0, "R10 C equal T");
    run_window(12, 0, "R10 C equal 1.5T");
    run_window(16, 0, "R10 C equal 2T");
    run_window(17, 0, "R6 C just above 2T");
    run_window(4, 0, "R10 C equal T/2");
    run_window(0, 1, "R9 only last-tick event");
    run_window(30, 0, "R5 dense burst");

    // random: sparse ticks, prescale incl. 0, varying target, toggling enable
    tag = "R3 random";
    for (int w = 0; w < 12; w++) begin
      prescale = 8'($urandom_range(0, 2));
      target = 6'($urandom_range(2, 63));
      if (w == 9) pace_en = 1'b0;
      if (w == 10) pace_en = 1'b1;
      for (int j = 0; j < 900; j++)
        step(1'($urandom_range(0, 3) != 0), ($urandom_range(0, 9) < 2));
    end
    tag = "R1 reapply";
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(irq_out, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule